// File: doc/BRIEF.md
# Three-Wire Staged Serial Control Loader

This block takes control words from a host over three wires: a frame enable, a serial data line and a serial clock. It runs on its own system clock and oversamples all three lines. Each line passes through a two-flop synchronizer, and the block finds clock falls and enable rises from the synchronized levels. During an enable window it counts serial clock falls and shifts one data bit in on each fall.

A frame holds 27 bits. The first 4 bits are a band-switch code. The next 15 bits are a divider setting, made of a 10-bit main count followed by a 5-bit swallow count. The last 8 bits are test bits. Each group is committed to its output register as soon as its final bit arrives, and does not wait for the end of the frame. A host can therefore send a short frame that changes only the band-switch code. Every commit raises a one-cycle strobe next to the register it changed.

Top module: `serial_ctrl_loader`

## Requirements
- R1: After reset the band, main-count, swallow-count and test registers are all zero, and all three strobes are low.
- R2: A bit is taken only on a falling edge of `ser_clk` while `ser_en` is high. Falls that occur while `ser_en` is low change no register and raise no strobe.
- R3: `band_sel` is loaded at the 4th fall of a frame. The first bit of the frame goes to `band_sel[3]` and the fourth bit goes to `band_sel[0]`.
- R4: `main_cnt` and `swallow_cnt` are loaded in the same cycle, at the 19th fall. Frame bits 5 to 14 fill `main_cnt` with bit 5 as its MSB. Frame bits 15 to 19 fill `swallow_cnt` with bit 15 as its MSB.
- R5: If a frame ends (enable low) before its 19th fall, only `band_sel` can change, and only if the 4th fall was reached. The partial divider bits are discarded.
- R6: `test_bits` is loaded at the 27th fall from frame bits 20 to 27. Bit 20 goes to `test_bits[7]`.
- R7: Falls after the 27th in the same enable window change no register and raise no strobe.
- R8: Each commit pulses its own strobe (`band_upd`, `div_upd`, `test_upd`) high for exactly one system clock, in the same cycle as the register change. A register never changes while its strobe is low. A commit appears on the third rising system clock edge after the serial fall is presented at the pins.
- R9: A rising edge of `ser_en` resets the fall count to zero, so a frame aborted part way leaves no bits behind for the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_en | input | 1 | Frame enable, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_clk | input | 1 | Serial clock, asynchronous; data is taken on its fall |
| band_sel | output | 4 | Band-switch code |
| band_upd | output | 1 | One-cycle pulse when band_sel is loaded |
| main_cnt | output | 10 | Main divider count |
| swallow_cnt | output | 5 | Swallow divider count |
| div_upd | output | 1 | One-cycle pulse when both divider counts are loaded |
| test_bits | output | 8 | Stored test bits |
| test_upd | output | 1 | One-cycle pulse when test_bits is loaded |

## Verification
The hardest cases to reach are the frames that stop or restart part way. These include a frame that ends between the 4th and 19th falls, and one that ends before the 4th. They also include an enable that drops after a few bits and rises again, where a stale count would misalign every later field. The stimulus sends short frames of chosen lengths, sends falls with the enable low, and sends extra falls past bit 27. After each case it sends a full frame with new values, so that any leftover count or bits would show up in the register contents. A behavioural model in the bench tracks the expected registers and strobes, applying each serial fall three system clocks after it is driven, and the outputs are compared against it on every cycle.

// File: rtl/scl_pkg.sv
package scl_pkg;
    // Default field widths and synchronizer depth
    parameter int unsigned BAND_W_DEF      = 4;
    parameter int unsigned MAIN_W_DEF      = 10;
    parameter int unsigned SWALLOW_W_DEF   = 5;
    parameter int unsigned TEST_W_DEF      = 8;
    parameter int unsigned SYNC_STAGES_DEF = 2;

    // Lane positions in the synchronized line vector
    localparam int unsigned LANE_CLK = 0;
    localparam int unsigned LANE_DAT = 1;
    localparam int unsigned LANE_EN  = 2;
    localparam int unsigned LANES    = 3;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction
endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < int'(STAGES); i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < int'(STAGES); g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/scl_deframer.sv
module scl_deframer #(
    parameter int unsigned BAND_W    = 4,
    parameter int unsigned MAIN_W    = 10,
    parameter int unsigned SWALLOW_W = 5,
    parameter int unsigned TEST_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_s,
    input  logic                 sclk_s,
    input  logic                 dat_s,
    output logic [BAND_W-1:0]    band_o,
    output logic                 band_stb_o,
    output logic [MAIN_W-1:0]    main_o,
    output logic [SWALLOW_W-1:0] swallow_o,
    output logic                 div_stb_o,
    output logic [TEST_W-1:0]    test_o,
    output logic                 test_stb_o
);
    localparam int unsigned DIV_W    = MAIN_W + SWALLOW_W;
    localparam int unsigned BAND_END = BAND_W;
    localparam int unsigned DIV_END  = BAND_END + DIV_W;
    localparam int unsigned TEST_END = DIV_END + TEST_W;
    localparam int unsigned CNT_W    = $clog2(TEST_END + 1);
    localparam int unsigned ACC_W    = scl_pkg::max3(BAND_W, DIV_W, TEST_W);

    localparam logic [CNT_W-1:0] BAND_AT = CNT_W'(BAND_END);
    localparam logic [CNT_W-1:0] DIV_AT  = CNT_W'(DIV_END);
    localparam logic [CNT_W-1:0] TEST_AT = CNT_W'(TEST_END);

    typedef struct packed {
        logic                 sclk_prev;
        logic                 en_prev;
        logic [CNT_W-1:0]     cnt;
        logic [ACC_W-1:0]     acc;
        logic [BAND_W-1:0]    band;
        logic                 band_stb;
        logic [MAIN_W-1:0]    main_c;
        logic [SWALLOW_W-1:0] swallow;
        logic                 div_stb;
        logic [TEST_W-1:0]    test;
        logic                 test_stb;
    } state_t;

    state_t           st_d, st_q;
    logic             en_rise, sclk_fall;
    logic [ACC_W-1:0] acc_next;
    logic [CNT_W-1:0] cnt_next;

    always_comb begin
        st_d           = st_q;
        st_d.band_stb  = 1'b0;
        st_d.div_stb   = 1'b0;
        st_d.test_stb  = 1'b0;
        st_d.sclk_prev = sclk_s;
        st_d.en_prev   = en_s;

        en_rise   = en_s & ~st_q.en_prev;
        sclk_fall = st_q.sclk_prev & ~sclk_s;
        acc_next  = {st_q.acc[ACC_W-2:0], dat_s};
        cnt_next  = st_q.cnt + 1'b1;

        if (en_rise) begin
            // new frame: restart the count and drop any partial bits
            st_d.cnt = '0;
            st_d.acc = '0;
        end else if (sclk_fall && en_s && (st_q.cnt != TEST_AT)) begin
            st_d.cnt = cnt_next;
            st_d.acc = acc_next;
            if (cnt_next == BAND_AT) begin
                st_d.band     = acc_next[BAND_W-1:0];
                st_d.band_stb = 1'b1;
            end
            if (cnt_next == DIV_AT) begin
                st_d.main_c  = acc_next[DIV_W-1:SWALLOW_W];
                st_d.swallow = acc_next[SWALLOW_W-1:0];
                st_d.div_stb = 1'b1;
            end
            if (cnt_next == TEST_AT) begin
                st_d.test     = acc_next[TEST_W-1:0];
                st_d.test_stb = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign band_o     = st_q.band;
    assign band_stb_o = st_q.band_stb;
    assign main_o     = st_q.main_c;
    assign swallow_o  = st_q.swallow;
    assign div_stb_o  = st_q.div_stb;
    assign test_o     = st_q.test;
    assign test_stb_o = st_q.test_stb;
endmodule

// File: rtl/serial_ctrl_loader.sv
module serial_ctrl_loader #(
    parameter int unsigned BAND_W      = scl_pkg::BAND_W_DEF,
    parameter int unsigned MAIN_W      = scl_pkg::MAIN_W_DEF,
    parameter int unsigned SWALLOW_W   = scl_pkg::SWALLOW_W_DEF,
    parameter int unsigned TEST_W      = scl_pkg::TEST_W_DEF,
    parameter int unsigned SYNC_STAGES = scl_pkg::SYNC_STAGES_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_en,
    input  logic                 ser_dat,
    input  logic                 ser_clk,
    output logic [BAND_W-1:0]    band_sel,
    output logic                 band_upd,
    output logic [MAIN_W-1:0]    main_cnt,
    output logic [SWALLOW_W-1:0] swallow_cnt,
    output logic                 div_upd,
    output logic [TEST_W-1:0]    test_bits,
    output logic                 test_upd
);
    localparam int unsigned LANES = scl_pkg::LANES;

    logic [LANES-1:0] lines_raw;
    logic [LANES-1:0] lines_s;

    always_comb begin
        lines_raw                    = '0;
        lines_raw[scl_pkg::LANE_CLK] = ser_clk;
        lines_raw[scl_pkg::LANE_DAT] = ser_dat;
        lines_raw[scl_pkg::LANE_EN]  = ser_en;
    end

    scl_sync #(
        .WIDTH (LANES),
        .STAGES(SYNC_STAGES)
    ) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(lines_raw),
        .sync_o (lines_s)
    );

    scl_deframer #(
        .BAND_W   (BAND_W),
        .MAIN_W   (MAIN_W),
        .SWALLOW_W(SWALLOW_W),
        .TEST_W   (TEST_W)
    ) deframer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_s      (lines_s[scl_pkg::LANE_EN]),
        .sclk_s    (lines_s[scl_pkg::LANE_CLK]),
        .dat_s     (lines_s[scl_pkg::LANE_DAT]),
        .band_o    (band_sel),
        .band_stb_o(band_upd),
        .main_o    (main_cnt),
        .swallow_o (swallow_cnt),
        .div_stb_o (div_upd),
        .test_o    (test_bits),
        .test_stb_o(test_upd)
    );
endmodule

// File: rtl/scl_checker.sv
module scl_checker #(
    parameter int unsigned BAND_W    = 4,
    parameter int unsigned MAIN_W    = 10,
    parameter int unsigned SWALLOW_W = 5,
    parameter int unsigned TEST_W    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ser_en,
    input logic [BAND_W-1:0]    band_sel,
    input logic                 band_upd,
    input logic [MAIN_W-1:0]    main_cnt,
    input logic [SWALLOW_W-1:0] swallow_cnt,
    input logic                 div_upd,
    input logic [TEST_W-1:0]    test_bits,
    input logic                 test_upd
);
    assert_band_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !band_upd |-> $stable(band_sel));

    assert_div_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !div_upd |-> ($stable(main_cnt) && $stable(swallow_cnt)));

    assert_test_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !test_upd |-> $stable(test_bits));

    assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({band_upd, div_upd, test_upd}));

    assert_strobe_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (band_upd || div_upd || test_upd) |=> !(band_upd || div_upd || test_upd));

    assert_enable_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (band_upd || div_upd || test_upd) |-> $past(ser_en, 3));
endmodule

bind serial_ctrl_loader scl_checker #(
    .BAND_W   (BAND_W),
    .MAIN_W   (MAIN_W),
    .SWALLOW_W(SWALLOW_W),
    .TEST_W   (TEST_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_en     (ser_en),
    .band_sel   (band_sel),
    .band_upd   (band_upd),
    .main_cnt   (main_cnt),
    .swallow_cnt(swallow_cnt),
    .div_upd    (div_upd),
    .test_bits  (test_bits),
    .test_upd   (test_upd)
);

// File: tb/serial_ctrl_loader_tb_top.sv
module serial_ctrl_loader_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 4;
    localparam int LAT        = 3;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_en = 1'b0, ser_dat = 1'b0, ser_clk = 1'b0;
    logic [3:0] band_sel;
    logic       band_upd, div_upd, test_upd;
    logic [9:0] main_cnt;
    logic [4:0] swallow_cnt;
    logic [7:0] test_bits;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_ctrl_loader dut_i (
        .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_dat(ser_dat), .ser_clk(ser_clk),
        .band_sel(band_sel), .band_upd(band_upd), .main_cnt(main_cnt),
        .swallow_cnt(swallow_cnt), .div_upd(div_upd), .test_bits(test_bits),
        .test_upd(test_upd)
    );

    int n_chk = 0;
    int n_err = 0;
    int cycle = 0;
    bit done  = 0;

    always @(posedge clk) cycle <= cycle + 1;

    // reference model state
    typedef struct {
        int          due;
        int          kind;
        logic [26:0] val;
    } ev_t;
    ev_t         evq[$];
    bit          m_en = 0;
    int          m_n = 0;
    logic [26:0] m_word = '0;
    logic [3:0]  x_band = '0;
    logic [9:0]  x_main = '0;
    logic [4:0]  x_swal = '0;
    logic [7:0]  x_test = '0;
    bit          x_bs, x_ds, x_ts;
    bit          cmp_on = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            x_bs = 0; x_ds = 0; x_ts = 0;
            while (evq.size() > 0 && evq[0].due == cycle) begin
                case (evq[0].kind)
                    0: begin x_band = evq[0].val[3:0]; x_bs = 1; end
                    1: begin x_main = evq[0].val[14:5]; x_swal = evq[0].val[4:0]; x_ds = 1; end
                    default: begin x_test = evq[0].val[7:0]; x_ts = 1; end
                endcase
                void'(evq.pop_front());
            end
            check(band_sel == x_band, "R3 band_sel", band_sel, x_band);
            check(main_cnt == x_main, "R4 main_cnt", main_cnt, x_main);
            check(swallow_cnt == x_swal, "R4 swallow_cnt", swallow_cnt, x_swal);
            check(test_bits == x_test, "R6 test_bits", test_bits, x_test);
            check(band_upd == x_bs, "R8 band_upd", band_upd, x_bs);
            check(div_upd == x_ds, "R8 div_upd", div_upd, x_ds);
            check(test_upd == x_ts, "R8 test_upd", test_upd, x_ts);
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_ev(input int kind);
        ev_t e;
        e.due  = cycle + LAT;
        e.kind = kind;
        e.val  = m_word;
        evq.push_back(e);
    endtask

    task automatic send_bit(input logic b);
        ser_dat = b;
        ser_clk = 1'b1;
        wait_n(HALF_BIT);
        ser_clk = 1'b0;
        if (m_en && m_n < 27) begin
            m_n++;
            m_word = {m_word[25:0], b};
            if (m_n == 4)  push_ev(0);
            if (m_n == 19) push_ev(1);
            if (m_n == 27) push_ev(2);
        end
        wait_n(HALF_BIT);
    endtask

    task automatic start_frame();
        ser_en = 1'b1;
        m_en   = 1;
        m_n    = 0;
        m_word = '0;
        wait_n(HALF_BIT);
    endtask

    task automatic end_frame();
        wait_n(2);
        ser_en = 1'b0;
        m_en   = 0;
        wait_n(HALF_BIT + LAT);
    endtask

    task automatic send_bits(input logic [26:0] w, input int n);
        for (int i = 0; i < n; i++) send_bit(w[26-i]);
    endtask

    function automatic logic [26:0] pack(input logic [3:0] b, input logic [9:0] m,
                                          input logic [4:0] s, input logic [7:0] t);
        return {b, m, s, t};
    endfunction

    task automatic check_regs(input string tag, input logic [3:0] b, input logic [9:0] m,
                              input logic [4:0] s, input logic [7:0] t);
        check(band_sel == b, {tag, " band"}, band_sel, b);
        check(main_cnt == m, {tag, " main"}, main_cnt, m);
        check(swallow_cnt == s, {tag, " swallow"}, swallow_cnt, s);
        check(test_bits == t, {tag, " test"}, test_bits, t);
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);
        // R1: reset state
        check_regs("R1 reset", 4'h0, 10'h0, 5'h0, 8'h0);
        check({band_upd, div_upd, test_upd} == 3'b000, "R1 strobes", {band_upd, div_upd, test_upd}, 0);
        cmp_on = 1;

        // full frame (R3 R4 R6)
        start_frame();
        send_bits(pack(4'hA, 10'h2C5, 5'h13, 8'h5A), 27);
        end_frame();
        check_regs("R4 full frame", 4'hA, 10'h2C5, 5'h13, 8'h5A);

        // full frame followed by extra falls (R7)
        start_frame();
        send_bits(pack(4'h3, 10'h1F0, 5'h0E, 8'hC3), 27);
        send_bits(27'h7FFFFFF, 5);
        end_frame();
        check_regs("R7 extra falls", 4'h3, 10'h1F0, 5'h0E, 8'hC3);

        // aborted after 10 bits: only band changes (R5)
        start_frame();
        send_bits(pack(4'h6, 10'h3FF, 5'h1F, 8'hFF), 10);
        end_frame();
        check_regs("R5 abort at 10", 4'h6, 10'h1F0, 5'h0E, 8'hC3);

        // aborted after 2 bits: nothing changes (R5)
        start_frame();
        send_bits(pack(4'hF, 10'h0, 5'h0, 8'h0), 2);
        end_frame();
        check_regs("R5 abort at 2", 4'h6, 10'h1F0, 5'h0E, 8'hC3);

        // falls while enable low are ignored (R2)
        send_bits(27'h5555555, 8);
        wait_n(LAT + 2);
        check_regs("R2 enable low", 4'h6, 10'h1F0, 5'h0E, 8'hC3);

        // frame ended after 19 bits: divider loads, test untouched (R4 R6)
        start_frame();
        send_bits(pack(4'h9, 10'h155, 5'h0A, 8'h00), 19);
        end_frame();
        check_regs("R6 stop at 19", 4'h9, 10'h155, 5'h0A, 8'hC3);

        // enable restart mid-frame resets the count (R9)
        start_frame();
        send_bits(27'h2AAAAAA, 7);
        end_frame();
        start_frame();
        send_bits(pack(4'h1, 10'h3A7, 5'h15, 8'h81), 27);
        end_frame();
        check_regs("R9 restart", 4'h1, 10'h3A7, 5'h15, 8'h81);

        // all-ones and all-zeros boundary values (R3 R4 R6)
        start_frame();
        send_bits(27'h7FFFFFF, 27);
        end_frame();
        check_regs("R3 all ones", 4'hF, 10'h3FF, 5'h1F, 8'hFF);
        start_frame();
        send_bits(27'h0, 27);
        end_frame();
        check_regs("R3 all zeros", 4'h0, 10'h0, 5'h0, 8'h00);

        wait_n(4);
        check(evq.size() == 0, "R8 pending updates", evq.size(), 0);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired R8 actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule